// File: doc/BRIEF.md
# Parallel ROM Read Controller

This block sits on the host side of an asynchronous parallel ROM whose data width is chosen by a pin. A requester hands it an address, a width select and a valid strobe. The controller then drives chip enable, output enable, the 23-bit address and the width pin. It holds them for a fixed number of clock cycles that covers the access time, captures the data and offers it back with a valid flag until the requester takes it.

In 8-bit mode the ROM's top data pin turns into the lowest address input. The controller drives bit 0 of the 24-bit byte address onto that pin and returns the byte zero-extended to 16 bits. In 16-bit mode the controller releases the pin and reads it as data bit 15.

A change of width gets its own settling phase, with the chip deselected, before the access starts. Each access ends with a recovery phase that lets the ROM release its outputs before anything else drives the shared pin. Every wait is derived from nanosecond parameters and the clock period. The level that enables the ROM's outputs is a build option.

Top module: `prom_rd_ctrl`

## Requirements
- R1: After reset: `rom_ce_n` is 1, `rom_oe` is at its inactive level, `rom_word` is 1 (16-bit mode), `rom_sh_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A 16-bit request (`req_word`=1) drives `req_addr[22:0]` onto `rom_addr` and ignores `req_addr[23]`. The shared pin is released (`rom_sh_oe`=0). `rsp_data` equals the full 16-bit `rom_dq_i`, with bit 15 taken from the shared pin.
- R3: An 8-bit request (`req_word`=0) drives `req_addr[23:1]` onto `rom_addr` and drives `req_addr[0]` on `rom_sh_o` with `rom_sh_oe`=1. `rsp_data` is `{8'h00, rom_dq_i[7:0]}`, and `rom_dq_i[15:8]` has no effect.
- R4: Chip enable stays low for exactly ACC_WAIT cycles, which is ceil(max(address access, output-enable access)/clock period) and 6 at the defaults. The data is captured on the edge that ends that window, and `rsp_valid` is 1 in the cycle where `rom_ce_n` returns high.
- R5: `rom_oe` is at its active level exactly while `rom_ce_n` is low. OE_OPT=0 is active low, OE_OPT=1 is active high, and OE_OPT=2 (ROM ignores the pin) follows the active-low pattern.
- R6: When a request's width differs from the last width driven, `rom_word` changes while `rom_ce_n` is high. Chip enable then falls only after MODE_WAIT cycles, which is 6 at the defaults.
- R7: When the width matches the last width driven, chip enable falls in the cycle right after the request is accepted.
- R8: After an access, chip enable stays high for at least TURN_WAIT+1 cycles before the next access begins, with TURN_WAIT=1 at the defaults. A request is accepted only while `rom_ce_n` is high.
- R9: The response and its data are held until `rsp_ready` is 1. While a response is pending, `req_ready` is 0 and a waiting request does not start an access.
- R10: `rom_addr`, `rom_word` and `rom_sh_o` stay stable while `rom_ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 24 | Byte address (8-bit mode) or word address in bits 22:0 (16-bit mode) |
| req_word | input | 1 | 1 selects 16-bit access, 0 selects 8-bit access |
| rsp_valid | output | 1 | Response data available |
| rsp_data | output | 16 | Read data, zero-extended in 8-bit mode |
| rsp_ready | input | 1 | Requester takes the response |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe | output | 1 | ROM output enable, polarity set by OE_OPT |
| rom_word | output | 1 | ROM width pin, 1 for 16-bit |
| rom_addr | output | 23 | ROM address pins |
| rom_sh_o | output | 1 | Value for the shared top pin (lowest byte-address bit) |
| rom_sh_oe | output | 1 | Drive enable for the shared top pin |
| rom_dq_i | input | 16 | ROM data pins; bit 15 reads the shared pin |

## Verification
A wrong phase counter shows at the pins at once. Chip enable stays low for more or fewer than six cycles, or it falls too soon after a width change or after the previous access. This is visible within one access. A stale width register appears as a missing or extra settling phase on the very next request, or as a shared pin driven in 16-bit mode. Errors in data steering, such as an unmasked upper byte or a wrong address shift, show up in the first response of the affected mode, because the ROM model encodes both the address pins and the shared pin into the data it returns.

// File: rtl/prom_pkg.sv
package prom_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SWITCH  = 2'd1,
      ST_ACCESS  = 2'd2,
      ST_RECOVER = 2'd3
   } prom_state_e;

   // output-enable polarity options
   localparam int OE_ACT_LOW  = 0;
   localparam int OE_ACT_HIGH = 1;
   localparam int OE_IGNORED  = 2;

   function automatic int cyc_ceil(input int ns, input int period_ns);
      return (ns + period_ns - 1) / period_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/prom_wait_timer.sv
module prom_wait_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/prom_oe_drv.sv
module prom_oe_drv
   import prom_pkg::*;
#(
   parameter int OE_OPT = OE_ACT_LOW
) (
   input  logic enable,
   output logic oe_pin
);

   generate
      if (OE_OPT == OE_ACT_HIGH) begin : g_high
         assign oe_pin = enable;
      end else begin : g_low
         // active-low, also used when the ROM ignores the pin
         assign oe_pin = ~enable;
      end
      if (OE_OPT < OE_ACT_LOW || OE_OPT > OE_IGNORED) begin : g_bad_opt
         $error("prom_oe_drv: OE_OPT out of range");
      end
   endgenerate

endmodule

// File: rtl/prom_data_fmt.sv
module prom_data_fmt #(
   parameter int DATA_W = 16
) (
   input  logic              word_mode,
   input  logic [DATA_W-1:0] bus,
   output logic [DATA_W-1:0] data
);

   localparam int BYTE_W = DATA_W / 2;

   generate
      if (DATA_W % 2 != 0) begin : g_bad_w
         $error("prom_data_fmt: DATA_W must be even");
      end
   endgenerate

   assign data = word_mode ? bus : {{(DATA_W - BYTE_W){1'b0}}, bus[BYTE_W-1:0]};

endmodule

// File: rtl/prom_rd_ctrl.sv
module prom_rd_ctrl
   import prom_pkg::*;
#(
   parameter int ADDR_W    = 23,
   parameter int DATA_W    = 16,
   parameter int CLK_NS    = 20,
   parameter int T_ACC_NS  = 120,
   parameter int T_OE_NS   = 25,
   parameter int T_MODE_NS = 120,
   parameter int T_DF_NS   = 20,
   parameter int OE_OPT    = OE_ACT_LOW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W:0]   req_addr,
   input  logic              req_word,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   input  logic              rsp_ready,
   output logic              rom_ce_n,
   output logic              rom_oe,
   output logic              rom_word,
   output logic [ADDR_W-1:0] rom_addr,
   output logic              rom_sh_o,
   output logic              rom_sh_oe,
   input  logic [DATA_W-1:0] rom_dq_i
);

   localparam int ACC_WAIT  = imax(cyc_ceil(T_ACC_NS, CLK_NS), cyc_ceil(T_OE_NS, CLK_NS));
   localparam int MODE_WAIT = cyc_ceil(T_MODE_NS, CLK_NS);
   localparam int TURN_WAIT = imax(cyc_ceil(T_DF_NS, CLK_NS), 1);
   localparam int MAX_WAIT  = imax(imax(ACC_WAIT, MODE_WAIT), TURN_WAIT);
   localparam int CW        = $clog2(MAX_WAIT + 1);
   localparam int KW        = $clog2(MAX_WAIT + 2) + 1;
   localparam logic [CW-1:0] ACC_LD  = CW'(ACC_WAIT - 1);
   localparam logic [CW-1:0] MODE_LD = CW'(MODE_WAIT - 1);
   localparam logic [CW-1:0] TURN_LD = CW'(TURN_WAIT - 1);

   generate
      if (ACC_WAIT < 1 || MODE_WAIT < 1) begin : g_bad_wait
         $error("prom_rd_ctrl: wait counts must be at least one cycle");
      end
      if (ADDR_W < 2 || DATA_W < 2) begin : g_bad_width
         $error("prom_rd_ctrl: address or data width too small");
      end
   endgenerate

   prom_state_e       state_q;
   logic              mode_q;
   logic              lsb_q;
   logic              ce_n_q;
   logic [ADDR_W-1:0] addr_q;
   logic              rsp_valid_q;
   logic [DATA_W-1:0] rsp_data_q;
   logic              tmr_load;
   logic [CW-1:0]     tmr_val;
   logic              tmr_zero;
   logic [DATA_W-1:0] fmt_data;
   logic              accept;
   logic              need_switch;

   assign req_ready   = (state_q == ST_IDLE) && !rsp_valid_q;
   assign accept      = req_valid && req_ready;
   assign need_switch = (req_word != mode_q);

   prom_wait_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   prom_data_fmt #(.DATA_W(DATA_W)) u_fmt (
      .word_mode (mode_q),
      .bus       (rom_dq_i),
      .data      (fmt_data)
   );

   prom_oe_drv #(.OE_OPT(OE_OPT)) u_oe (
      .enable (!ce_n_q),
      .oe_pin (rom_oe)
   );

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state_q)
         ST_IDLE: begin
            if (accept) begin
               tmr_load = 1'b1;
               tmr_val  = need_switch ? MODE_LD : ACC_LD;
            end
         end
         ST_SWITCH: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               tmr_val  = ACC_LD;
            end
         end
         ST_ACCESS: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               tmr_val  = TURN_LD;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         mode_q      <= 1'b1;
         lsb_q       <= 1'b0;
         ce_n_q      <= 1'b1;
         addr_q      <= '0;
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         if (rsp_valid_q && rsp_ready) begin
            rsp_valid_q <= 1'b0;
         end
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  addr_q <= req_word ? req_addr[ADDR_W-1:0] : req_addr[ADDR_W:1];
                  lsb_q  <= req_word ? 1'b0 : req_addr[0];
                  mode_q <= req_word;
                  if (need_switch) begin
                     state_q <= ST_SWITCH;
                  end else begin
                     state_q <= ST_ACCESS;
                     ce_n_q  <= 1'b0;
                  end
               end
            end
            ST_SWITCH: begin
               if (tmr_zero) begin
                  state_q <= ST_ACCESS;
                  ce_n_q  <= 1'b0;
               end
            end
            ST_ACCESS: begin
               if (tmr_zero) begin
                  rsp_data_q  <= fmt_data;
                  rsp_valid_q <= 1'b1;
                  ce_n_q      <= 1'b1;
                  state_q     <= ST_RECOVER;
               end
            end
            default: begin
               if (tmr_zero) begin
                  state_q <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assign rom_ce_n  = ce_n_q;
   assign rom_word  = mode_q;
   assign rom_addr  = addr_q;
   assign rom_sh_o  = lsb_q;
   assign rom_sh_oe = !mode_q;
   assign rsp_valid = rsp_valid_q;
   assign rsp_data  = rsp_data_q;

   // ---------------- timing monitors for the assertions ----------------
   logic [KW-1:0] low_cnt_q;
   logic [KW-1:0] high_cnt_q;
   logic [KW-1:0] mode_age_q;
   logic          word_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt_q  <= '0;
         high_cnt_q <= KW'(TURN_WAIT + 1);
         mode_age_q <= KW'(MODE_WAIT);
         word_d_q   <= 1'b1;
      end else begin
         word_d_q   <= rom_word;
         low_cnt_q  <= rom_ce_n ? '0 : ((low_cnt_q < KW'(MAX_WAIT + 1)) ? low_cnt_q + 1'b1 : low_cnt_q);
         high_cnt_q <= !rom_ce_n ? '0 : ((high_cnt_q < KW'(TURN_WAIT + 1)) ? high_cnt_q + 1'b1 : high_cnt_q);
         if (rom_word != word_d_q) begin
            mode_age_q <= KW'(1);
         end else if (mode_age_q < KW'(MODE_WAIT)) begin
            mode_age_q <= mode_age_q + 1'b1;
         end
      end
   end

   assert_access_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rom_ce_n) |-> (low_cnt_q == KW'(ACC_WAIT)));

   assert_oe_follows_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (OE_OPT == OE_ACT_HIGH) ? (rom_oe == !rom_ce_n) : (rom_oe == rom_ce_n));

   assert_mode_deselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rom_word) |-> rom_ce_n);

   assert_mode_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rom_ce_n) |-> (mode_age_q >= KW'(MODE_WAIT)));

   assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rom_ce_n) |-> (high_cnt_q >= KW'(TURN_WAIT + 1)));

   assert_accept_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> rom_ce_n);

   assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

   assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rom_word) |-> (rsp_data[DATA_W-1:DATA_W/2] == '0));

   assert_pins_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rom_ce_n && $past(!rom_ce_n)) |-> ($stable(rom_addr) && $stable(rom_word) && $stable(rom_sh_o)));

endmodule

// File: tb/prom_rd_ctrl_test.sv
module prom_rd_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [23:0] req_addr = '0;
   logic        req_word = 1'b1;
   logic        rsp_valid;
   logic [15:0] rsp_data;
   logic        rsp_ready = 1'b0;
   logic        rom_ce_n;
   logic        rom_oe;
   logic        rom_word;
   logic [22:0] rom_addr;
   logic        rom_sh_o;
   logic        rom_sh_oe;
   logic [15:0] rom_dq;

   int n_cmp = 0;
   int n_bad = 0;
   logic last_word = 1'b1;

   always #10 clk = ~clk;

   prom_rd_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_word(req_word),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
      .rom_ce_n(rom_ce_n), .rom_oe(rom_oe), .rom_word(rom_word), .rom_addr(rom_addr),
      .rom_sh_o(rom_sh_o), .rom_sh_oe(rom_sh_oe), .rom_dq_i(rom_dq)
   );

   // behavioural ROM: contents encode the address seen on the pins
   always_comb begin
      if (!rom_ce_n && !rom_oe) begin
         if (rom_word) rom_dq = rom_addr[15:0] ^ 16'h3C5A;
         else rom_dq = {(rom_sh_oe ? rom_sh_o : 1'b1), 7'h55, {rom_addr[6:0], rom_sh_o} ^ 8'h96};
      end else begin
         rom_dq = 16'hA5A5;
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 ce_n", rom_ce_n, 1);
      chk("R1 oe inactive", rom_oe, 1);
      chk("R1 width pin", rom_word, 1);
      chk("R1 shared released", rom_sh_oe, 0);
      chk("R1 rsp_valid", rsp_valid, 0);
      chk("R1 req_ready", req_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic read_op(input logic [23:0] a, input logic w);
      int pre;
      int low;
      int unstable;
      logic [22:0] exp_addr;
      logic [15:0] exp_data;
      exp_addr = w ? a[22:0] : a[23:1];
      exp_data = w ? (a[15:0] ^ 16'h3C5A) : {8'h00, a[7:0] ^ 8'h96};
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_word = w;
      @(negedge clk);
      req_valid = 1'b0;
      pre = 0;
      while (rom_ce_n && pre < 50) begin pre++; @(negedge clk); end
      if (w != last_word) chk("R6 settle cycles before CE", pre, 6);
      else chk("R7 no settle when width unchanged", pre, 0);
      chk(w ? "R2 address pins" : "R3 address pins", rom_addr, exp_addr);
      chk("R6 width pin", rom_word, w);
      chk(w ? "R2 shared pin released" : "R3 shared pin driven", rom_sh_oe, !w);
      if (!w) chk("R3 shared pin carries lsb", rom_sh_o, a[0]);
      chk("R5 oe active low", rom_oe, 0);
      low = 0; unstable = 0;
      while (!rom_ce_n && low < 50) begin
         if (rom_addr !== exp_addr || rom_word !== w || rom_oe !== 1'b0) unstable++;
         low++;
         @(negedge clk);
      end
      chk("R10 pins stable during access", unstable, 0);
      chk("R4 CE low cycles", low, 6);
      chk("R4 response valid after CE rises", rsp_valid, 1);
      chk(w ? "R2 word data" : "R3 byte data zero-extended", rsp_data, exp_data);
      last_word = w;
   endtask

   task automatic take_rsp();
      logic [15:0] held;
      held = rsp_data;
      req_valid = 1'b1; req_addr = 24'h000055; req_word = last_word;
      repeat (3) begin
         @(negedge clk);
         chk("R9 response held", rsp_valid, 1);
         chk("R9 data held", rsp_data, held);
         chk("R9 waiting request not started", rom_ce_n, 1);
      end
      chk("R9 not ready while pending", req_ready, 0);
      req_valid = 1'b0;
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk("R9 response released", rsp_valid, 0);
   endtask

   task automatic t_gap();
      int gap;
      int guard;
      rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 24'h000777; req_word = 1'b1;
      guard = 0;
      while (rom_ce_n && guard < 50) begin guard++; @(negedge clk); end
      req_addr = 24'h000778;
      guard = 0;
      while (!rom_ce_n && guard < 50) begin guard++; @(negedge clk); end
      gap = 0;
      while (rom_ce_n && gap < 50) begin gap++; @(negedge clk); end
      req_valid = 1'b0;
      chk("R8 CE high gap back to back", gap, 2);
      chk("R8 second address", rom_addr, 23'h000778);
      guard = 0;
      while (!rom_ce_n && guard < 50) begin guard++; @(negedge clk); end
      chk("R8 second response valid", rsp_valid, 1);
      chk("R2 second word data", rsp_data, 16'h0778 ^ 16'h3C5A);
      @(negedge clk);
      rsp_ready = 1'b0;
      last_word = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      read_op(24'h001234, 1'b1); take_rsp();
      read_op(24'hFFFFFF, 1'b1); take_rsp();   // R2: bit 23 ignored, top address
      read_op(24'h00ABCD, 1'b0); take_rsp();   // R6 switch to byte, odd address
      read_op(24'hFFFFFE, 1'b0); take_rsp();   // R7 same width, even top address
      read_op(24'h000042, 1'b1); take_rsp();   // R6 switch back to word
      t_gap();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule